// File: doc/BRIEF.md
# Receiver Gain Divider Controller

This block owns the 10-bit setting of a receiver input attenuator built from switchable parallel resistors. A setting of 0x000 adds no switchable resistor and gives the most sensitive input. A setting of 0x3FF adds every resistor in parallel and gives the most robust input. When closed-loop control is on, the block reads a one-bit comparator result once per programmable period. It then moves the setting one step toward the reference level and stops at either end of the range.

All control sits in one configuration word, written with a single-cycle write strobe. The word holds the run enable, the fix-mode behaviour, the preload source, a self-clearing load strobe, the update time constant and a 2-bit reference-level select. The reference-level select goes to the comparator side unchanged. When the loop is off, the setting follows one of two preload inputs or stays frozen at its last value. A load strobe copies a preload into the setting in any mode, including while the loop runs.

Top module: `rx_gain_ctrl`

## Requirements
- R1: After reset, `gain_o`, `vref_sel_o` and every bit of `cfg_rdata_o` are 0.
- R2: A write to the configuration word stores its fields in one cycle: time constant in [9:0], reference select in [11:10], run in [12], freeze in [13], source in [14] and load in [15]. `cfg_rdata_o` returns them in the same positions, and bit 15 always reads 0.
- R3: A write whose reference-select field is 2'b11 leaves the stored select and `vref_sel_o` at their previous value. The other fields of that write still take effect.
- R4: A write with load = 1 sets `gain_o` at the write edge to `preset_b_i` when the word's source bit is 1, or to `preset_a_i` when it is 0.
- R5: With run = 1, the setting updates once every (TC + 1) clock cycles. Any configuration write restarts the period, so the first update lands TC + 1 cycles after the write edge.
- R6: A time constant below 4 behaves exactly like 4, which gives a period of 5 cycles.
- R7: At each update, `cmp_above_i` = 1 raises the setting by one and `cmp_above_i` = 0 lowers it by one.
- R8: The closed loop saturates: it never goes from 0x3FF to 0x000 or from 0x000 to 0x3FF.
- R9: With run = 0 and freeze = 1, `gain_o` does not change, whatever the preload inputs or the comparator do, until a load.
- R10: With run = 0 and freeze = 0, `gain_o` follows the preload picked by the stored source bit (1 = `preset_b_i`) one cycle behind.
- R11: A load while the loop runs takes effect at once, and the loop steps on from the loaded value one full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Configuration write word |
| preset_a_i | input | 10 | First preload source |
| preset_b_i | input | 10 | Second preload source |
| cmp_above_i | input | 1 | Comparator: 1 = level above reference |
| gain_o | output | 10 | Current divider setting |
| vref_sel_o | output | 2 | Reference-level select to the comparator |
| cfg_rdata_o | output | 16 | Configuration readback |

## Verification
The configuration readback, the reference select and a loaded setting all change at the write edge itself. Tracking in fix mode shows up one edge after a preload input changes. Closed-loop steps land exactly TC + 1 (or 5) edges after the write that restarted the period. Each expected value is queued with the absolute edge number at which it is due. The monitor compares it on the falling edge after that edge, and it also probes the edge just before a step to show that nothing moved early.

// File: rtl/rx_gain_pkg.sv
package rx_gain_pkg;
  localparam int GAIN_W_DEF = 10;
  localparam int TC_W_DEF   = 10;
  localparam int TC_MIN_DEF = 4;
  localparam logic [1:0] VREF_RSVD = 2'b11;

  typedef enum logic [1:0] {
    GSEL_HOLD,
    GSEL_LOAD,
    GSEL_STEP,
    GSEL_TRACK
  } gsel_e;
endpackage

// File: rtl/rx_gain_cfg.sv
module rx_gain_cfg
  import rx_gain_pkg::*;
#(
  parameter int TC_W = TC_W_DEF,
  localparam int CFG_W = TC_W + 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic             run_o,
  output logic             freeze_o,
  output logic             src_o,
  output logic [1:0]       vref_o,
  output logic [TC_W-1:0]  tc_o,
  output logic             load_o,
  output logic             load_src_o,
  output logic             restart_o,
  output logic [CFG_W-1:0] rdata_o
);
  localparam int VREF_LSB = TC_W;
  localparam int RUN_BIT  = TC_W + 2;
  localparam int FRZ_BIT  = TC_W + 3;
  localparam int SRC_BIT  = TC_W + 4;
  localparam int LOAD_BIT = TC_W + 5;

  logic [1:0] vref_in;
  assign vref_in = wdata_i[VREF_LSB +: 2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o    <= 1'b0;
      freeze_o <= 1'b0;
      src_o    <= 1'b0;
      vref_o   <= '0;
      tc_o     <= '0;
    end else if (we_i) begin
      run_o    <= wdata_i[RUN_BIT];
      freeze_o <= wdata_i[FRZ_BIT];
      src_o    <= wdata_i[SRC_BIT];
      tc_o     <= wdata_i[TC_W-1:0];
      // reserved encoding keeps the previous select
      if (vref_in != VREF_RSVD) vref_o <= vref_in;
    end
  end

  assign load_o     = we_i & wdata_i[LOAD_BIT];
  assign load_src_o = wdata_i[SRC_BIT];
  assign restart_o  = we_i;
  assign rdata_o    = {1'b0, src_o, freeze_o, run_o, vref_o, tc_o};
endmodule

// File: rtl/rx_gain_timer.sv
module rx_gain_timer
  import rx_gain_pkg::*;
#(
  parameter int TC_W   = TC_W_DEF,
  parameter int TC_MIN = TC_MIN_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            restart_i,
  input  logic [TC_W-1:0] tc_i,
  output logic            tick_o
);
  localparam logic [TC_W-1:0] TC_FLOOR = TC_W'(TC_MIN);

  logic [TC_W-1:0] cnt_q;
  logic [TC_W-1:0] limit;

  assign limit  = (tc_i < TC_FLOOR) ? TC_FLOOR : tc_i;
  assign tick_o = run_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (restart_i || !run_i)  cnt_q <= '0;
    else if (tick_o)               cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rx_gain_step.sv
module rx_gain_step
  import rx_gain_pkg::*;
#(
  parameter int GAIN_W = GAIN_W_DEF
) (
  input  logic [GAIN_W-1:0] cur_i,
  input  logic              up_i,
  output logic [GAIN_W-1:0] nxt_o
);
  localparam logic [GAIN_W-1:0] G_MAX = '1;
  localparam logic [GAIN_W-1:0] G_MIN = '0;

  always_comb begin
    if (up_i) nxt_o = (cur_i == G_MAX) ? cur_i : cur_i + 1'b1;
    else      nxt_o = (cur_i == G_MIN) ? cur_i : cur_i - 1'b1;
  end
endmodule

// File: rtl/rx_gain_ctrl.sv
module rx_gain_ctrl
  import rx_gain_pkg::*;
#(
  parameter int GAIN_W = GAIN_W_DEF,
  parameter int TC_W   = TC_W_DEF,
  parameter int TC_MIN = TC_MIN_DEF,
  localparam int CFG_W = TC_W + 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic [GAIN_W-1:0] preset_a_i,
  input  logic [GAIN_W-1:0] preset_b_i,
  input  logic              cmp_above_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic [1:0]        vref_sel_o,
  output logic [CFG_W-1:0]  cfg_rdata_o
);
  logic            run, freeze, src, load, load_src, restart, tick;
  logic [TC_W-1:0] tc;
  logic [GAIN_W-1:0] gain_q, gain_d, step_val, load_val, track_val;
  gsel_e gsel;

  rx_gain_cfg #(.TC_W(TC_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .wdata_i    (cfg_wdata_i),
    .run_o      (run),
    .freeze_o   (freeze),
    .src_o      (src),
    .vref_o     (vref_sel_o),
    .tc_o       (tc),
    .load_o     (load),
    .load_src_o (load_src),
    .restart_o  (restart),
    .rdata_o    (cfg_rdata_o)
  );

  rx_gain_timer #(.TC_W(TC_W), .TC_MIN(TC_MIN)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .restart_i (restart),
    .tc_i      (tc),
    .tick_o    (tick)
  );

  rx_gain_step #(.GAIN_W(GAIN_W)) u_step (
    .cur_i (gain_q),
    .up_i  (cmp_above_i),
    .nxt_o (step_val)
  );

  assign load_val  = load_src ? preset_b_i : preset_a_i;
  assign track_val = src ? preset_b_i : preset_a_i;

  // load wins over loop step, loop over fix-mode tracking
  always_comb begin
    if (load)                 gsel = GSEL_LOAD;
    else if (tick)            gsel = GSEL_STEP;
    else if (!run && !freeze) gsel = GSEL_TRACK;
    else                      gsel = GSEL_HOLD;
  end

  always_comb begin
    unique case (gsel)
      GSEL_LOAD:  gain_d = load_val;
      GSEL_STEP:  gain_d = step_val;
      GSEL_TRACK: gain_d = track_val;
      default:    gain_d = gain_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gain_q <= '0;
    else         gain_q <= gain_d;
  end

  assign gain_o = gain_q;
endmodule

// File: rtl/rx_gain_ctrl_chk.sv
module rx_gain_ctrl_chk #(
  parameter int GAIN_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic              wr_load_i,
  input logic              wr_src_i,
  input logic              run_i,
  input logic              freeze_i,
  input logic              src_i,
  input logic              rd_load_i,
  input logic [GAIN_W-1:0] preset_a_i,
  input logic [GAIN_W-1:0] preset_b_i,
  input logic [GAIN_W-1:0] gain_o,
  input logic [1:0]        vref_sel_o
);
  logic [GAIN_W-1:0] gain_prev, delta;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gain_prev <= '0;
    else         gain_prev <= gain_o;
  end
  assign delta = gain_o - gain_prev;

  assert_load_reads_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_load_i == 1'b0);

  assert_vref_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vref_sel_o != 2'b11);

  assert_load_copies_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && wr_load_i) |=>
      gain_o == ($past(wr_src_i) ? $past(preset_b_i) : $past(preset_a_i)));

  assert_single_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && run_i) |=> (delta == '0 || delta == GAIN_W'(1) || delta == '1));

  assert_no_wrap_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && run_i && gain_o == '1) |=> gain_o != '0);

  assert_no_wrap_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && run_i && gain_o == '0) |=> gain_o != '1);

  assert_freeze_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && !run_i && freeze_i) |=> $stable(gain_o));

  assert_track_a_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && !run_i && !freeze_i && !src_i) |=> gain_o == $past(preset_a_i));

  assert_track_b_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && !run_i && !freeze_i && src_i) |=> gain_o == $past(preset_b_i));
endmodule

bind rx_gain_ctrl rx_gain_ctrl_chk #(.GAIN_W(GAIN_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .wr_load_i  (cfg_wdata_i[TC_W+5]),
  .wr_src_i   (cfg_wdata_i[TC_W+4]),
  .run_i      (cfg_rdata_o[TC_W+2]),
  .freeze_i   (cfg_rdata_o[TC_W+3]),
  .src_i      (cfg_rdata_o[TC_W+4]),
  .rd_load_i  (cfg_rdata_o[TC_W+5]),
  .preset_a_i (preset_a_i),
  .preset_b_i (preset_b_i),
  .gain_o     (gain_o),
  .vref_sel_o (vref_sel_o)
);

// File: tb/rx_gain_ctrl_test.sv
module rx_gain_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [9:0]  pa = '0, pb = '0;
  logic        cmp = 1'b0;
  logic [9:0]  gain;
  logic [1:0]  vref;
  logic [15:0] rdata;

  always #2 clk = ~clk;  // 250 MHz

  rx_gain_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .preset_a_i(pa), .preset_b_i(pb), .cmp_above_i(cmp),
    .gain_o(gain), .vref_sel_o(vref), .cfg_rdata_o(rdata)
  );

  typedef struct {
    int          due;
    int          kind;  // 0 gain, 1 readback, 2 vref
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t sq[$];
  int cyc = 0;
  int vec = 0;
  int bad = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare every item due at the edge just passed
  always @(negedge clk) begin
    for (int i = sq.size() - 1; i >= 0; i--) begin
      if (sq[i].due == cyc) begin
        logic [15:0] act;
        act = (sq[i].kind == 0) ? {6'b0, gain} :
              (sq[i].kind == 1) ? rdata : {14'b0, vref};
        vec++;
        if (act !== sq[i].exp) begin
          bad++;
          $display("FAIL %s kind=%0d edge=%0d actual=%h expected=%h",
                   sq[i].req, sq[i].kind, cyc, act, sq[i].exp);
        end
        sq.delete(i);
      end
    end
  end

  function automatic logic [15:0] mk(bit ld, bit src, bit frz, bit run,
                                     logic [1:0] vr, logic [9:0] tc);
    return {ld, src, frz, run, vr, tc};
  endfunction

  task automatic push(int due, int kind, logic [15:0] exp, string req);
    item_t it;
    it.due = due; it.kind = kind; it.exp = exp; it.req = req;
    sq.push_back(it);
  endtask

  task automatic gexp(int due, logic [9:0] g, string req);
    push(due, 0, {6'b0, g}, req);
  endtask

  // caller is at a falling edge; the write lands at edge cyc+1
  task automatic wr(logic [15:0] w);
    we = 1'b1; wdata = w;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    int e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    push(cyc + 1, 0, 16'h0, "R1");
    push(cyc + 1, 1, 16'h0, "R1");
    push(cyc + 1, 2, 16'h0, "R1");
    @(negedge clk); @(negedge clk);

    // R2 readback, R3 reserved select ignored
    e = cyc + 1;
    push(e, 1, mk(0, 0, 1, 0, 2'b01, 10'd5), "R2");
    push(e, 2, 16'h1, "R2");
    wr(mk(0, 0, 1, 0, 2'b01, 10'd5));
    e = cyc + 1;
    push(e, 1, mk(0, 0, 1, 0, 2'b01, 10'd9), "R3");
    push(e, 2, 16'h1, "R3");
    wr(mk(0, 0, 1, 0, 2'b11, 10'd9));

    // R4 load from each source, load bit reads 0 (R2)
    pa = 10'h155; pb = 10'h0C3;
    e = cyc + 1;
    gexp(e, 10'h155, "R4");
    push(e, 1, mk(0, 0, 1, 0, 2'b01, 10'd5), "R2");
    wr(mk(1, 0, 1, 0, 2'b01, 10'd5));
    // R9 frozen despite preload and comparator changes
    pa = 10'h000; cmp = 1'b1;
    gexp(cyc + 15, 10'h155, "R9");
    wait_to(cyc + 16);
    pb = 10'h2AA;
    e = cyc + 1;
    gexp(e, 10'h2AA, "R4");
    wr(mk(1, 1, 1, 0, 2'b01, 10'd5));

    // R5 / R7 closed loop, period 8
    cmp = 1'b1;
    e = cyc + 1;
    gexp(e + 7, 10'h2AA, "R5");
    gexp(e + 8, 10'h2AB, "R5");
    gexp(e + 15, 10'h2AB, "R7");
    gexp(e + 16, 10'h2AA, "R7");
    gexp(e + 24, 10'h2A9, "R7");
    wr(mk(0, 1, 1, 1, 2'b01, 10'd7));
    wait_to(e + 9);
    cmp = 1'b0;
    wait_to(e + 25);

    // R6 small time constant, R11 load while running
    pa = 10'h100; cmp = 1'b1;
    e = cyc + 1;
    gexp(e, 10'h100, "R11");
    gexp(e + 4, 10'h100, "R6");
    gexp(e + 5, 10'h101, "R6");
    gexp(e + 10, 10'h102, "R11");
    wr(mk(1, 0, 1, 1, 2'b01, 10'd2));
    wait_to(e + 11);

    // R8 saturation at both ends
    pa = 10'h3FE; cmp = 1'b1;
    e = cyc + 1;
    gexp(e + 5, 10'h3FF, "R8");
    gexp(e + 10, 10'h3FF, "R8");
    gexp(e + 15, 10'h3FF, "R8");
    wr(mk(1, 0, 1, 1, 2'b01, 10'd4));
    wait_to(e + 16);
    pa = 10'h001; cmp = 1'b0;
    e = cyc + 1;
    gexp(e + 5, 10'h000, "R8");
    gexp(e + 10, 10'h000, "R8");
    wr(mk(1, 0, 1, 1, 2'b01, 10'd4));
    wait_to(e + 11);

    // R9 freeze the last loop value
    pa = 10'h010; cmp = 1'b1;
    e = cyc + 1;
    gexp(e + 5, 10'h011, "R7");
    wr(mk(1, 0, 1, 1, 2'b01, 10'd4));
    wait_to(e + 6);
    e = cyc + 1;
    gexp(e + 1, 10'h011, "R9");
    gexp(e + 15, 10'h011, "R9");
    wr(mk(0, 0, 1, 0, 2'b01, 10'd4));
    pa = 10'h3C0;
    wait_to(e + 16);

    // R10 fix-mode tracking of the selected preload
    pb = 10'h0F0; pa = 10'h123;
    e = cyc + 1;
    gexp(e, 10'h011, "R10");
    gexp(e + 1, 10'h0F0, "R10");
    wr(mk(0, 1, 0, 0, 2'b01, 10'd4));
    wait_to(e + 2);
    pb = 10'h0AB;
    gexp(cyc + 1, 10'h0AB, "R10");
    wait_to(e + 4);
    e = cyc + 1;
    gexp(e + 1, 10'h123, "R10");
    wr(mk(0, 0, 0, 0, 2'b01, 10'd4));
    wait_to(e + 4);

    if (sq.size() != 0) begin
      bad++;
      $display("FAIL queue: %0d items never checked, expected 0", sq.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule